// File: doc/BRIEF.md
# Answer-to-Reset and Block Timing Monitor

This block watches the timing of a smart card session. It derives an elementary time unit (etu) tick from the reference clock in two stages. A baud prescaler divides the reference clock by one plus a programmable baud value. An etu stage then counts a programmable number of baud periods. All protocol windows are counted in whole etu ticks.

Three windows are monitored. The character window applies while answer-to-reset mode is on. It checks the gap between the leading edges of the start bits of consecutive received characters. The duration window runs from the first received start edge of the answer-to-reset. It ends 12 etu after the last start edge, and the limit is nominally 19200 etu. The block window runs from the strobe for the last character sent to the card until the first start edge the card sends back.

Each overrun gives a one-cycle hit pulse and sets a sticky raw status bit. Software clears these bits by writing ones to a clear port. A mask register selects which raw bits appear in the masked status. All masked bits are ORed into one interrupt line. The strobes and register write ports are plain single-cycle control pins, so no handshake or back-pressure applies to them.

Top module: `atr_timing_monitor`

## Requirements
- R1: `etu_tick` is a one-cycle pulse. Its period is (1 + `baud_div`) × max(`etu_len`, 1) clock cycles. A zero etu length counts as one.
- R2: While `atr_mode` is high, each `rx_start` restarts the character window. If `chr_limit` + 1 etu ticks pass with no further start, `chr_hit` pulses once and raw status bit 8 is set. A gap of at most `chr_limit` ticks between starts sets nothing.
- R3: While `atr_mode` is low, `rx_start` neither arms the character window nor opens the duration window. Lowering `atr_mode` disarms the character window without a hit.
- R4: The duration window opens at the first `rx_start` seen in `atr_mode`. Raw status bit 6 is set, with a `dur_hit` pulse, exactly when (last start + 12 etu) − first start exceeds `dur_limit` etu. The window closes once `atr_mode` is low and 12 etu have passed since the last start.
- R5: `tx_last` arms the block window. If no `rx_start` arrives within `blk_limit` etu ticks, `blk_hit` pulses one cycle and raw status bit 7 is set. When ticks come every cycle, the pulse is visible in the (`blk_limit` + 1)-th cycle after the cycle in which `tx_last` is sampled.
- R6: A window raises its hit at most once. A further hit needs a new arming strobe.
- R7: Raw status bits are sticky. Writing with `clr_we` high clears each bit where `clr_wdata` is 1. Bits where `clr_wdata` is 0, and writes with `clr_we` low, leave bits unchanged. A set in the same cycle as a clear wins.
- R8: `mask_q` holds the last value written with `mask_we`. `masked_status` equals raw status AND mask, and `irq` is the OR of `masked_status`.
- R9: After reset, raw status, mask, masked status, `irq` and all hit outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset |
| baud_div | input | BW | Baud prescaler value (divide by 1 + value) |
| etu_len | input | EW | Baud periods per etu (0 treated as 1) |
| chr_limit | input | TW | Character gap limit in etu |
| dur_limit | input | TW | Answer-to-reset duration limit in etu |
| blk_limit | input | TW | Block wait limit in etu |
| atr_mode | input | 1 | High during answer-to-reset reception |
| rx_start | input | 1 | Strobe: start-bit leading edge of a received character |
| tx_last | input | 1 | Strobe: leading edge of the last character sent |
| mask_we | input | 1 | Mask register write enable |
| mask_wdata | input | SW | Mask write data |
| clr_we | input | 1 | Status clear write enable |
| clr_wdata | input | SW | Write-one-to-clear data |
| etu_tick | output | 1 | One-cycle etu pulse |
| chr_hit | output | 1 | Character timeout pulse |
| dur_hit | output | 1 | Duration timeout pulse |
| blk_hit | output | 1 | Block timeout pulse |
| raw_status | output | SW | Sticky raw status (bits 6, 7, 8 used) |
| mask_q | output | SW | Mask register |
| masked_status | output | SW | Raw status AND mask |
| irq | output | 1 | OR of masked status |

## Verification
Hit pulses come from registered counters and the current tick. With a tick on every cycle, a hit is visible in the cycle after the limit-th tick following its strobe. The matching raw bit is set one edge later. `irq` and `masked_status` follow the raw bits in the same cycle. Inputs change on falling edges, and outputs are read on falling edges. Outcome checks wait 20 cycles after the last strobe, which covers the 13-cycle duration tail. The block hit position is checked cycle-exactly by counting falling edges from the strobe. The tick period is measured between two consecutive pulses, after two pulses have been skipped to absorb a divider reprogram.

// File: rtl/atm_pkg.sv
package atm_pkg;
  localparam int DUR_BIT  = 6;
  localparam int BLK_BIT  = 7;
  localparam int CHR_BIT  = 8;
  localparam int TAIL_ETU = 12;
endpackage

// File: rtl/atm_etu_gen.sv
module atm_etu_gen #(
  parameter int BW = 8,
  parameter int EW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] baud_div,
  input  logic [EW-1:0] etu_len,
  output logic          tick
);
  logic [BW-1:0] bcnt;
  logic [EW-1:0] ecnt;
  logic          baud_pulse;
  logic [EW-1:0] etu_last;

  // >= compares keep the divider safe when values shrink mid-count
  assign baud_pulse = (bcnt >= baud_div);
  assign etu_last   = (etu_len == '0) ? '0 : etu_len - 1'b1;
  assign tick       = baud_pulse && (ecnt >= etu_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= '0;
      ecnt <= '0;
    end else begin
      bcnt <= baud_pulse ? '0 : bcnt + 1'b1;
      if (baud_pulse) ecnt <= (ecnt >= etu_last) ? '0 : ecnt + 1'b1;
    end
  end
endmodule

// File: rtl/atm_gap_timer.sv
module atm_gap_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  input  logic          start,  // arm and restart count
  input  logic          done,   // disarm after this edge, hit still allowed
  input  logic          kill,   // disarm and suppress hit
  output logic          hit
);
  logic          armed;
  logic [TW-1:0] cnt;

  assign hit = armed && tick && (cnt == limit) && !kill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (start) begin
      armed <= 1'b1;
      cnt   <= '0;
    end else if (kill || done || hit) begin
      armed <= 1'b0;
    end else if (armed && tick) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/atm_dur_timer.sv
module atm_dur_timer
  import atm_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  input  logic          atr_mode,
  input  logic          rx_start,
  output logic          hit
);
  localparam int TAIL_W = $clog2(TAIL_ETU + 1);
  localparam logic [TAIL_W-1:0] TAIL_END = TAIL_W'(TAIL_ETU);

  logic              open;
  logic [TW-1:0]     dcnt;
  logic [TAIL_W-1:0] tail;
  logic              close;
  logic              atr_start;

  assign atr_start = atr_mode && rx_start;
  assign close     = open && !atr_mode && (tail >= TAIL_END);
  assign hit       = open && tick && (dcnt == limit) && !close;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open <= 1'b0;
      dcnt <= '0;
      tail <= '0;
    end else if (!open) begin
      if (atr_start) begin
        open <= 1'b1;
        dcnt <= '0;
        tail <= '0;
      end
    end else if (close || hit) begin
      open <= 1'b0;
    end else begin
      if (tick) dcnt <= dcnt + 1'b1;
      if (atr_start)                       tail <= '0;
      else if (tick && (tail < TAIL_END)) tail <= tail + 1'b1;
    end
  end
endmodule

// File: rtl/atm_irq_regs.sv
module atm_irq_regs #(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] set_vec,
  input  logic          mask_we,
  input  logic [SW-1:0] mask_wdata,
  input  logic          clr_we,
  input  logic [SW-1:0] clr_wdata,
  output logic [SW-1:0] raw,
  output logic [SW-1:0] mask,
  output logic [SW-1:0] masked,
  output logic          irq
);
  logic [SW-1:0] clr_vec;

  assign clr_vec = clr_we ? clr_wdata : '0;
  assign masked  = raw & mask;
  assign irq     = |masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw  <= '0;
      mask <= '0;
    end else begin
      raw <= (raw & ~clr_vec) | set_vec;
      if (mask_we) mask <= mask_wdata;
    end
  end
endmodule

// File: rtl/atr_timing_monitor.sv
module atr_timing_monitor
  import atm_pkg::*;
#(
  parameter int BW = 8,
  parameter int EW = 8,
  parameter int TW = 16,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] baud_div,
  input  logic [EW-1:0] etu_len,
  input  logic [TW-1:0] chr_limit,
  input  logic [TW-1:0] dur_limit,
  input  logic [TW-1:0] blk_limit,
  input  logic          atr_mode,
  input  logic          rx_start,
  input  logic          tx_last,
  input  logic          mask_we,
  input  logic [SW-1:0] mask_wdata,
  input  logic          clr_we,
  input  logic [SW-1:0] clr_wdata,
  output logic          etu_tick,
  output logic          chr_hit,
  output logic          dur_hit,
  output logic          blk_hit,
  output logic [SW-1:0] raw_status,
  output logic [SW-1:0] mask_q,
  output logic [SW-1:0] masked_status,
  output logic          irq
);
  logic [SW-1:0] set_vec;

  atm_etu_gen #(.BW(BW), .EW(EW)) u_etu (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .etu_len(etu_len),
    .tick(etu_tick)
  );

  atm_gap_timer #(.TW(TW)) u_chr (
    .clk(clk), .rst_n(rst_n), .tick(etu_tick), .limit(chr_limit),
    .start(atr_mode && rx_start), .done(1'b0), .kill(!atr_mode),
    .hit(chr_hit)
  );

  atm_gap_timer #(.TW(TW)) u_blk (
    .clk(clk), .rst_n(rst_n), .tick(etu_tick), .limit(blk_limit),
    .start(tx_last), .done(rx_start), .kill(1'b0),
    .hit(blk_hit)
  );

  atm_dur_timer #(.TW(TW)) u_dur (
    .clk(clk), .rst_n(rst_n), .tick(etu_tick), .limit(dur_limit),
    .atr_mode(atr_mode), .rx_start(rx_start), .hit(dur_hit)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[CHR_BIT] = chr_hit;
    set_vec[DUR_BIT] = dur_hit;
    set_vec[BLK_BIT] = blk_hit;
  end

  atm_irq_regs #(.SW(SW)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .clr_we(clr_we), .clr_wdata(clr_wdata),
    .raw(raw_status), .mask(mask_q), .masked(masked_status), .irq(irq)
  );
endmodule

// File: rtl/atm_checker.sv
module atm_checker
  import atm_pkg::*;
#(
  parameter int BW = 8,
  parameter int SW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [BW-1:0] baud_div,
  input logic          tx_last,
  input logic          etu_tick,
  input logic          chr_hit,
  input logic          dur_hit,
  input logic          blk_hit,
  input logic [SW-1:0] raw_status,
  input logic [SW-1:0] mask_q,
  input logic          irq,
  input logic          clr_we,
  input logic [SW-1:0] clr_wdata
);
  logic [SW-1:0] clr_mask;
  assign clr_mask = clr_we ? clr_wdata : '0;

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (etu_tick && baud_div != '0) |=> (!etu_tick || !$stable(baud_div))); // R1

  AST_CHR_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    chr_hit |=> raw_status[CHR_BIT]); // R2

  AST_DUR_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    dur_hit |=> raw_status[DUR_BIT]); // R4

  AST_BLK_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    blk_hit |=> raw_status[BLK_BIT]); // R5

  AST_BLK_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_hit && !tx_last) |=> !blk_hit); // R6

  AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(raw_status) & ~$past(clr_mask) & ~raw_status) == '0)); // R7

  AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq); // R8
endmodule

bind atr_timing_monitor atm_checker #(.BW(BW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .tx_last(tx_last),
  .etu_tick(etu_tick), .chr_hit(chr_hit), .dur_hit(dur_hit),
  .blk_hit(blk_hit), .raw_status(raw_status), .mask_q(mask_q), .irq(irq),
  .clr_we(clr_we), .clr_wdata(clr_wdata)
);

// File: tb/tb_atr_timing_monitor.sv
module tb_atr_timing_monitor;
  localparam int BW = 8, EW = 8, TW = 16, SW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [BW-1:0] baud_div = '0;
  logic [EW-1:0] etu_len = 8'd1;
  logic [TW-1:0] chr_limit = 16'd1000, dur_limit = 16'd1000, blk_limit = 16'd1000;
  logic atr_mode = 1'b0, rx_start = 1'b0, tx_last = 1'b0;
  logic mask_we = 1'b0, clr_we = 1'b0;
  logic [SW-1:0] mask_wdata = '0, clr_wdata = '0;
  logic etu_tick, chr_hit, dur_hit, blk_hit, irq;
  logic [SW-1:0] raw_status, mask_q, masked_status;

  int total = 0, bad = 0, blk_hits = 0;

  always #10 clk = ~clk;

  atr_timing_monitor #(.BW(BW), .EW(EW), .TW(TW), .SW(SW)) dut (.*);

  always @(negedge clk) if (rst_n && blk_hit) blk_hits++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_all();
    @(negedge clk); clr_we = 1'b1; clr_wdata = '1;
    @(negedge clk); clr_we = 1'b0; clr_wdata = '0;
  endtask

  task automatic run_chr(input int lim, input int gap);
    clr_all(); chr_limit = TW'(lim); dur_limit = 16'd1000;
    @(negedge clk); atr_mode = 1'b1;
    @(negedge clk); rx_start = 1'b1;
    @(negedge clk); rx_start = 1'b0;
    step(gap - 1);
    rx_start = 1'b1;
    @(negedge clk); rx_start = 1'b0; atr_mode = 1'b0;
    step(20);
    chk(raw_status[8] == (gap > lim), "R2", raw_status[8], int'(gap > lim));
  endtask

  task automatic run_dur(input int lim, input int g);
    clr_all(); chr_limit = 16'd1000; dur_limit = TW'(lim);
    @(negedge clk); atr_mode = 1'b1;
    @(negedge clk); rx_start = 1'b1;
    @(negedge clk); rx_start = 1'b0;
    if (g > 0) begin
      step(g - 1);
      rx_start = 1'b1;
      @(negedge clk); rx_start = 1'b0;
    end
    atr_mode = 1'b0;
    step(20);
    chk(raw_status[6] == (g + 12 > lim), "R4", raw_status[6], int'(g + 12 > lim));
  endtask

  task automatic run_blk(input int lim, input int gap);
    clr_all(); blk_limit = TW'(lim);
    @(negedge clk); tx_last = 1'b1;
    @(negedge clk); tx_last = 1'b0;
    step(gap - 1);
    rx_start = 1'b1;
    @(negedge clk); rx_start = 1'b0;
    step(20);
    chk(raw_status[7] == (gap > lim), "R5", raw_status[7], int'(gap > lim));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hits0, first;
    step(3);
    // R9 reset state (sampled while still in reset and after release)
    chk(raw_status == '0 && mask_q == '0 && masked_status == '0 && !irq,
        "R9", int'(raw_status), 0);
    rst_n = 1'b1;
    step(2);
    chk(raw_status == '0 && mask_q == '0 && !chr_hit && !dur_hit && !blk_hit,
        "R9", int'(raw_status), 0);

    // R1 tick period sweep
    for (int b = 0; b < 4; b++) begin
      for (int e = 0; e < 5; e++) begin
        int n, per;
        baud_div = BW'(b); etu_len = EW'(e);
        per = (b + 1) * ((e == 0) ? 1 : e);
        for (int s = 0; s < 2; s++) begin
          do @(negedge clk); while (!etu_tick);
        end
        n = 0;
        do begin @(negedge clk); n++; end while (!etu_tick);
        chk(n == per, "R1", n, per);
      end
    end
    baud_div = '0; etu_len = 8'd1;

    // R2 character gap sweep
    for (int l = 0; l < 5; l++)
      for (int g = 1; g < 8; g++) run_chr(l, g);

    // R3 starts ignored outside ATR mode
    clr_all(); chr_limit = 16'd2; dur_limit = 16'd5;
    @(negedge clk); rx_start = 1'b1;
    @(negedge clk); rx_start = 1'b0;
    step(9);
    rx_start = 1'b1;
    @(negedge clk); rx_start = 1'b0;
    step(30);
    chk(raw_status[8] == 1'b0, "R3", raw_status[8], 0);
    chk(raw_status[6] == 1'b0, "R3", raw_status[6], 0);
    // R3 dropping mode disarms the character window
    clr_all(); chr_limit = 16'd5; dur_limit = 16'd1000;
    @(negedge clk); atr_mode = 1'b1;
    @(negedge clk); rx_start = 1'b1;
    @(negedge clk); rx_start = 1'b0; atr_mode = 1'b0;
    step(30);
    chk(raw_status[8] == 1'b0, "R3", raw_status[8], 0);

    // R4 duration sweep
    for (int l = 10; l < 18; l++)
      for (int g = 0; g < 6; g++) run_dur(l, g);

    // R5 block sweep
    for (int l = 0; l < 5; l++)
      for (int g = 1; g < 8; g++) run_blk(l, g);

    // R5 exact hit cycle and R6 single hit
    clr_all(); blk_limit = 16'd3;
    hits0 = blk_hits; first = 0;
    @(negedge clk); tx_last = 1'b1;
    for (int k = 1; k <= 15; k++) begin
      @(negedge clk);
      tx_last = 1'b0;
      if (blk_hit && first == 0) first = k;
    end
    chk(first == 4, "R5", first, 4);
    chk(blk_hits - hits0 == 1, "R6", blk_hits - hits0, 1);
    chk(raw_status[7] == 1'b1, "R5", raw_status[7], 1);
    clr_all();
    step(30);
    chk(raw_status[7] == 1'b0, "R6", raw_status[7], 0);

    // R7 write-one-to-clear behaviour
    clr_all(); blk_limit = 16'd1;
    @(negedge clk); tx_last = 1'b1;
    @(negedge clk); tx_last = 1'b0;
    step(10);
    @(negedge clk); clr_we = 1'b1; clr_wdata = 16'h0040;
    @(negedge clk); clr_we = 1'b0; clr_wdata = '0;
    chk(raw_status[7] == 1'b1, "R7", raw_status[7], 1);
    @(negedge clk); clr_we = 1'b0; clr_wdata = 16'h0080;
    @(negedge clk); clr_wdata = '0;
    chk(raw_status[7] == 1'b1, "R7", raw_status[7], 1);

    // R8 mask, masked status, irq
    chk(irq == 1'b0 && masked_status == '0, "R8", int'(irq), 0);
    @(negedge clk); mask_we = 1'b1; mask_wdata = 16'h0080;
    @(negedge clk); mask_we = 1'b0; mask_wdata = '0;
    chk(mask_q == 16'h0080, "R8", int'(mask_q), 'h80);
    chk(masked_status == 16'h0080 && irq, "R8", int'(masked_status), 'h80);
    @(negedge clk); mask_we = 1'b1; mask_wdata = 16'h0140;
    @(negedge clk); mask_we = 1'b0;
    chk(!irq && masked_status == '0, "R8", int'(irq), 0);
    @(negedge clk); clr_we = 1'b1; clr_wdata = 16'h0080;
    @(negedge clk); clr_we = 1'b0; clr_wdata = '0;
    chk(raw_status[7] == 1'b0, "R7", raw_status[7], 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule